// File: doc/BRIEF.md
# Serial Configuration PROM Emulator

This block takes the place of a small three-wire serial configuration PROM that a network controller reads at power-up. The controller drives the serial clock; the block brings that clock into its own clock domain, counts its cycles, and answers each read frame with one 16-bit configuration word from a built-in table. While the emulation runs, it holds a select line high that switches the controller over to the emulated device.

The command and address bits that the reader clocks in are not decoded. Every frame is 32 serial-clock cycles long. The first 11 cycles are a quiet lead-in, the next 16 carry one word, and the last 5 are a quiet trailer. After a single start pulse the table is streamed word by word. When the last word's trailer ends, the block pulses a done flag and releases its outputs.

A presence monitor runs next to the streamer. After start it waits for any level change on the serial clock. If a change is seen, it reports that a reader is present. If a bounded counter wraps first, it reports that no reader is attached.

Top module: `cfg_prom_emu`

## Requirements
- R1: During and after reset, do_out, emu_sel, done, present and absent are all low.
- R2: Serial-clock edges that arrive before start is asserted leave do_out, emu_sel and present low.
- R3: One cycle after start is sampled high, emu_sel is high and do_out is low. emu_sel stays high until the final frame ends.
- R4: During the first 11 serial-clock cycles of every frame, do_out stays low.
- R5: Serial-clock cycles 11 to 26 of a frame (counting from 0) carry the word. The byte at the even table index goes first, then the next byte, and each byte is sent most significant bit first. A 1 bit drives do_out high.
- R6: do_out takes the data bit within 3 system clocks of a rising serial-clock level at the input. Within 3 system clocks of a falling level it is forced back low.
- R7: The 5 serial-clock cycles after the data bits keep do_out low, and the next frame then starts at cycle 0.
- R8: The table holds 18 bytes, served as 9 words in index order whatever the reader sends. Byte 3 is 0x30 and every other byte is 0xFF.
- R9: After the falling edge that ends the 9th frame, done is high for exactly one system clock, and from then on emu_sel and do_out are low.
- R10: The first serial-clock level change after start sets present, which then stays set.
- R11: If no serial-clock change follows start, absent rises between 2^TO_W and 2^TO_W+2 system clocks after the start cycle. It is low before that, and present and absent are never high together.
- R12: A new start pulse clears present and absent, restarts the frame position and the word index at zero, and drives do_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that arms or restarts the emulation |
| sk_in | input | 1 | Serial clock from the reader, asynchronous |
| do_out | output | 1 | Serial data toward the reader |
| emu_sel | output | 1 | High while the emulation runs |
| done | output | 1 | One-cycle pulse after the last frame |
| present | output | 1 | A serial-clock change was seen after start |
| absent | output | 1 | The presence timeout expired with no change |

## Verification
The bench builds the block with TO_W set to 6, so the presence timeout expires after 64 clocks and both edges of the absent window can be checked exactly. The table and frame geometry keep their default values. This lets the bench sweep every serial-clock cycle of all nine frames in both clock phases, with each expected bit computed from the table rule. An interrupted run is restarted after two words, which shows that the word index really returns to zero: the only 0x30 byte then has to appear again in the second frame.

// File: rtl/cfg_prom_pkg.sv
package cfg_prom_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] cfg_byte_t;

  // Table rule: one distinguished byte, the rest filled.
  function automatic cfg_byte_t table_byte(input int idx, input int sel_idx,
                                           input cfg_byte_t sel_val,
                                           input cfg_byte_t fill_val);
    return (idx == sel_idx) ? sel_val : fill_val;
  endfunction
endpackage

// File: rtl/cfg_prom_sync.sv
module cfg_prom_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/cfg_prom_table.sv
module cfg_prom_table
  import cfg_prom_pkg::*;
#(
  parameter int        NUM_BYTES = 18,
  parameter int        SEL_IDX   = 3,
  parameter cfg_byte_t SEL_VAL   = 8'h30,
  parameter cfg_byte_t FILL_VAL  = 8'hFF,
  localparam int       WORDS     = NUM_BYTES / 2,
  localparam int       WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic [WIDX_W-1:0]   widx,
  output logic [2*BYTE_W-1:0] word_q
);
  cfg_byte_t rom [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_rom
    assign rom[g] = table_byte(g, SEL_IDX, SEL_VAL, FILL_VAL);
  end

  logic [WIDX_W:0] addr_even;
  logic [WIDX_W:0] addr_odd;
  assign addr_even = {widx, 1'b0};
  assign addr_odd  = {widx, 1'b1};

  // Registered read; the index is stable long before the first data bit.
  always_ff @(posedge clk) begin
    word_q <= {rom[addr_even], rom[addr_odd]};
  end
endmodule

// File: rtl/cfg_prom_presence.sv
module cfg_prom_presence #(
  parameter int TO_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic edge_seen,
  output logic present,
  output logic absent
);
  logic            run_q;
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      present <= 1'b0;
      absent  <= 1'b0;
    end else if (start) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      present <= 1'b0;
      absent  <= 1'b0;
    end else if (run_q) begin
      if (edge_seen) begin
        present <= 1'b1;
        run_q   <= 1'b0;
      end else if (&cnt_q) begin
        absent  <= 1'b1;
        run_q   <= 1'b0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_prom_seq.sv
module cfg_prom_seq #(
  parameter int  PRE_CYCLES  = 11,
  parameter int  DATA_BITS   = 16,
  parameter int  POST_CYCLES = 5,
  parameter int  WORDS       = 9,
  localparam int FRAME       = PRE_CYCLES + DATA_BITS + POST_CYCLES,
  localparam int FPOS_W      = $clog2(FRAME),
  localparam int WIDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 sk_rise,
  input  logic                 sk_fall,
  input  logic [DATA_BITS-1:0] word_q,
  output logic [WIDX_W-1:0]    widx,
  output logic [FPOS_W-1:0]    fpos,
  output logic                 do_out,
  output logic                 emu_sel,
  output logic                 done
);
  localparam logic [FPOS_W-1:0] POS_LOAD  = FPOS_W'(PRE_CYCLES - 1);
  localparam logic [FPOS_W-1:0] POS_D0    = FPOS_W'(PRE_CYCLES);
  localparam logic [FPOS_W-1:0] POS_DEND  = FPOS_W'(PRE_CYCLES + DATA_BITS);
  localparam logic [FPOS_W-1:0] POS_LAST  = FPOS_W'(FRAME - 1);
  localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(WORDS - 1);

  logic [DATA_BITS-1:0] sh_q;
  logic                 in_data;

  assign in_data = (fpos >= POS_D0) && (fpos < POS_DEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      emu_sel <= 1'b0;
      do_out  <= 1'b0;
      done    <= 1'b0;
      fpos    <= '0;
      widx    <= '0;
      sh_q    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        emu_sel <= 1'b1;
        do_out  <= 1'b0;
        fpos    <= '0;
        widx    <= '0;
      end else if (emu_sel) begin
        if (sk_rise && in_data) begin
          do_out <= sh_q[DATA_BITS-1];
        end
        if (sk_fall) begin
          do_out <= 1'b0;
          if (fpos == POS_LOAD) begin
            sh_q <= word_q;
          end else if (in_data) begin
            sh_q <= {sh_q[DATA_BITS-2:0], 1'b0};
          end
          if (fpos == POS_LAST) begin
            fpos <= '0;
            if (widx == WIDX_LAST) begin
              emu_sel <= 1'b0;
              done    <= 1'b1;
            end else begin
              widx <= widx + 1'b1;
            end
          end else begin
            fpos <= fpos + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfg_prom_emu.sv
module cfg_prom_emu
  import cfg_prom_pkg::*;
#(
  parameter int        SYNC_STAGES = 2,
  parameter int        PRE_CYCLES  = 11,
  parameter int        POST_CYCLES = 5,
  parameter int        NUM_BYTES   = 18,
  parameter int        SEL_IDX     = 3,
  parameter cfg_byte_t SEL_VAL     = 8'h30,
  parameter cfg_byte_t FILL_VAL    = 8'hFF,
  parameter int        TO_W        = 16,
  localparam int       DATA_BITS   = 2 * BYTE_W,
  localparam int       WORDS       = NUM_BYTES / 2,
  localparam int       FRAME       = PRE_CYCLES + DATA_BITS + POST_CYCLES,
  localparam int       FPOS_W      = $clog2(FRAME),
  localparam int       WIDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sk_in,
  output logic do_out,
  output logic emu_sel,
  output logic done,
  output logic present,
  output logic absent
);
  logic                 sk_rise;
  logic                 sk_fall;
  logic [WIDX_W-1:0]    widx;
  logic [FPOS_W-1:0]    fpos;
  logic [DATA_BITS-1:0] word_q;

  cfg_prom_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sk_in),
    .rise     (sk_rise),
    .fall     (sk_fall)
  );

  cfg_prom_table #(
    .NUM_BYTES (NUM_BYTES),
    .SEL_IDX   (SEL_IDX),
    .SEL_VAL   (SEL_VAL),
    .FILL_VAL  (FILL_VAL)
  ) u_table (
    .clk    (clk),
    .widx   (widx),
    .word_q (word_q)
  );

  cfg_prom_seq #(
    .PRE_CYCLES  (PRE_CYCLES),
    .DATA_BITS   (DATA_BITS),
    .POST_CYCLES (POST_CYCLES),
    .WORDS       (WORDS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .sk_rise (sk_rise),
    .sk_fall (sk_fall),
    .word_q  (word_q),
    .widx    (widx),
    .fpos    (fpos),
    .do_out  (do_out),
    .emu_sel (emu_sel),
    .done    (done)
  );

  cfg_prom_presence #(.TO_W(TO_W)) u_presence (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .edge_seen (sk_rise | sk_fall),
    .present   (present),
    .absent    (absent)
  );
endmodule

// File: rtl/cfg_prom_emu_chk.sv
module cfg_prom_emu_chk #(
  parameter int  PRE_CYCLES = 11,
  parameter int  DATA_BITS  = 16,
  parameter int  FPOS_W     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              do_out,
  input logic              emu_sel,
  input logic              done,
  input logic              present,
  input logic              absent,
  input logic              sk_rise,
  input logic              sk_fall,
  input logic [FPOS_W-1:0] fpos
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !emu_sel |-> !do_out);

  p_lead_low_r4: assert property (@(posedge clk) disable iff (rst)
    (emu_sel && !start && sk_rise && fpos < FPOS_W'(PRE_CYCLES)) |=> !do_out);

  p_fall_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (emu_sel && sk_fall) |=> !do_out);

  p_trail_low_r7: assert property (@(posedge clk) disable iff (rst)
    (emu_sel && !start && sk_rise && fpos >= FPOS_W'(PRE_CYCLES + DATA_BITS)) |=> !do_out);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_release_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!emu_sel && !do_out));

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(present && absent));

  p_restart_arms_r12: assert property (@(posedge clk) disable iff (rst)
    start |=> (emu_sel && !do_out && !present && !absent));
endmodule

bind cfg_prom_emu cfg_prom_emu_chk #(
  .PRE_CYCLES (PRE_CYCLES),
  .DATA_BITS  (DATA_BITS),
  .FPOS_W     (FPOS_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .do_out  (do_out),
  .emu_sel (emu_sel),
  .done    (done),
  .present (present),
  .absent  (absent),
  .sk_rise (sk_rise),
  .sk_fall (sk_fall),
  .fpos    (fpos)
);

// File: tb/cfg_prom_emu_tb.sv
module cfg_prom_emu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO_W       = 6;
  localparam int HALF       = 4;
  localparam int PRE        = 11;
  localparam int DBITS      = 16;
  localparam int FRAME      = 32;
  localparam int WORDS      = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sk_in = 1'b0;
  logic do_out, emu_sel, done, present, absent;

  int total = 0;
  int fails = 0;
  int done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_prom_emu #(.TO_W(TO_W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .sk_in   (sk_in),
    .do_out  (do_out),
    .emu_sel (emu_sel),
    .done    (done),
    .present (present),
    .absent  (absent)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  endtask

  // R8 table rule
  function automatic logic [7:0] tbyte(input int idx);
    return (idx == 3) ? 8'h30 : 8'hFF;
  endfunction

  function automatic logic exp_bit(input int w, input int c);
    if (c < PRE || c >= PRE + DBITS) return 1'b0;
    return tbyte(2*w + (c - PRE)/8)[7 - ((c - PRE) % 8)];
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic sk_cycle(input logic hi_exp, input string req);
    sk_in = 1'b1;
    tick(HALF);
    chk(req, do_out, hi_exp);
    sk_in = 1'b0;
    tick(HALF);
    chk("R6 low after fall", do_out, 1'b0);
  endtask

  task automatic run_word(input int w);
    for (int c = 0; c < FRAME; c++) begin
      if (c < PRE)             sk_cycle(1'b0, "R4 lead-in low");
      else if (c < PRE+DBITS)  sk_cycle(exp_bit(w, c), "R5 R8 data bit");
      else                     sk_cycle(1'b0, "R7 trailer low");
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    join_none

    tick(3);
    chk("R1 do_out", do_out, 0);
    chk("R1 emu_sel", emu_sel, 0);
    chk("R1 done", done, 0);
    chk("R1 present", present, 0);
    chk("R1 absent", absent, 0);
    rst = 1'b0;
    tick(2);

    // R2: edges before start
    for (int i = 0; i < 3; i++) begin
      sk_in = 1'b1; tick(HALF);
      chk("R2 do_out idle", do_out, 0);
      sk_in = 1'b0; tick(HALF);
    end
    chk("R2 emu_sel idle", emu_sel, 0);
    chk("R2 present idle", present, 0);

    // R3 / R11: start with no clock
    pulse_start();
    chk("R3 emu_sel", emu_sel, 1);
    chk("R3 do_out", do_out, 0);
    tick((1 << TO_W) - 2);
    chk("R11 absent early", absent, 0);
    tick(4);
    chk("R11 absent set", absent, 1);
    chk("R11 present clear", present, 0);

    // Interrupted run, then restart (R12)
    pulse_start();
    chk("R12 absent cleared", absent, 0);
    run_word(0);
    chk("R10 present", present, 1);
    chk("R11 exclusive", absent, 0);
    run_word(1);
    for (int c = 0; c < 7; c++) sk_cycle(exp_bit(2, c), "R4 partial");
    pulse_start();
    chk("R12 present cleared", present, 0);
    chk("R12 do_out", do_out, 0);
    chk("R12 emu_sel", emu_sel, 1);

    // Full run from word 0
    done_cnt = 0;
    for (int w = 0; w < WORDS; w++) begin
      if (w < WORDS - 1) begin
        chk("R9 no early done", done_cnt, 0);
        chk("R3 emu_sel held", emu_sel, 1);
      end
      run_word(w);
    end
    chk("R9 done pulses", done_cnt, 1);
    chk("R9 emu_sel released", emu_sel, 0);
    chk("R9 do_out released", do_out, 0);
    chk("R10 present sticky", present, 1);

    // After done, further clocks produce nothing
    sk_in = 1'b1; tick(HALF);
    chk("R9 quiet after done", do_out, 0);
    sk_in = 1'b0; tick(HALF);
    chk("R9 no second done", done_cnt, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule